// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns two active-low, asynchronous interrupt pins into request lines for an interrupt arbiter. Each pin is first passed through a two-stage synchronizer. It is then sampled only when a sample strobe marks one of the fixed sampling points inside an instruction. The caller asserts that strobe at the chosen oscillator periods, aligned to the address latch strobe.

Each pin has one trigger-mode bit and one request-flag bit in a small control nibble that software can read and write. In falling-edge mode, a sample that sees the pin low after the previous sample saw it high sets the flag, and the flag drives the request. The flag then stays set until the interrupt controller vectors to that source or software clears it. In low-level mode the flag is bypassed. The request is the inverted last sample of the pin, so a pin that stays low keeps requesting.

Because the pin is only looked at on strobes, the pulse-width rules come from the spacing of those strobes. A low pulse that falls between two strobes is never seen. After an edge has been taken, the pin must be seen high at some strobe before a new edge counts.

Top module: `ext_irq_cond`

## Requirements
- R1: After a synchronous reset, every mode bit and every flag is 0, `irq_req` is 0 and `reg_rdata` is 0.
- R2: In the control nibble, the mode bit of pin i sits at bit 2i (1 = falling-edge, 0 = low-level) and the flag of pin i sits at bit 2i+1. A write with `reg_we` loads the whole nibble, and `reg_rdata` shows the new value after the next rising edge.
- R3: A pin is sampled only on a rising edge where `sample_stb` is high. A pin change is visible to a strobe no earlier than the third rising edge after the change. A low pulse that lies entirely between two strobes has no effect.
- R4: In falling-edge mode, a strobe whose sample is low while the previous sample was high sets the pin's flag, and `irq_req[i]` equals the flag.
- R5: In falling-edge mode, a pin held low across several strobes sets the flag only once. Once that flag has been cleared, it is not set again until the pin has been sampled high and then low.
- R6: In falling-edge mode, `vec_clr[i]` clears flag i on the next rising edge.
- R7: A flag-setting edge takes priority over a software write and over `vec_clr` in the same cycle, so the flag ends up 1.
- R8: In low-level mode, `irq_req[i]` is the inverse of the last sample of pin i. The pin and `vec_clr` leave the flag unchanged, and a flag written to 1 does not raise the request.
- R9: In low-level mode, a pin that is still low at a later strobe keeps `irq_req[i]` asserted, even after `vec_clr[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | NUM_PINS | Asynchronous active-low interrupt pins |
| sample_stb | input | 1 | High for one cycle at each sampling point |
| reg_we | input | 1 | Write strobe for the control nibble |
| reg_wdata | input | 2*NUM_PINS | Write data: mode at bit 2i, flag at bit 2i+1 |
| vec_clr | input | NUM_PINS | Flag-clear strobe from the controller on vectoring |
| irq_req | output | NUM_PINS | Request lines to the arbiter |
| reg_rdata | output | 2*NUM_PINS | Read value of the control nibble |

## Verification
The bench strobes one edge too early after a pin change. A design with a shorter synchronizer would set the flag there. It drives a low pulse between strobes, which a design that samples continuously would catch, and it holds a pin low across several strobes after clearing, which an edge detector that compares against the synchronizer rather than the last sample would re-trigger on. It collides an edge with a clear or a zero write to expose a wrong priority. It also checks that in level mode neither a written flag nor the vectoring clear changes the request, which a design that routes level requests through the flag would get wrong.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  function automatic int mode_bit(input int pin);
    return 2 * pin;
  endfunction

  function automatic int flag_bit(input int pin);
    return 2 * pin + 1;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '1;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '1;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic stb,
  input  logic we,
  input  logic wr_mode,
  input  logic wr_flag,
  input  logic vclr,
  output logic mode_q,
  output logic flag_q,
  output logic req_q
);
  logic samp_q;
  logic samp_d, mode_d, flag_d;
  logic edge_hit;

  assign edge_hit = stb && (mode_q == TRIG_FALL) && samp_q && !pin_s;

  always_comb begin
    samp_d = stb ? pin_s : samp_q;
    mode_d = we ? wr_mode : mode_q;
    if (edge_hit)                         flag_d = 1'b1;
    else if (we)                          flag_d = wr_flag;
    else if (mode_q == TRIG_FALL && vclr) flag_d = 1'b0;
    else                                  flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b1;
      mode_q <= TRIG_LEVEL;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      mode_q <= mode_d;
      flag_q <= flag_d;
      req_q  <= (mode_d == TRIG_FALL) ? flag_d : !samp_d;
    end
  end

  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (stb && mode_q && samp_q && !pin_s) |=> flag_q);

  assert_vec_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q && vclr && !we && !(stb && samp_q && !pin_s)) |=> !flag_q);

  assert_sample_only_on_stb_R3: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(samp_q));

  assert_level_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !we) |=> $stable(flag_q));
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_pin_n,
  input  logic                sample_stb,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [NUM_PINS-1:0] vec_clr,
  output logic [NUM_PINS-1:0] irq_req,
  output logic [REG_W-1:0]    reg_rdata
);
  logic [NUM_PINS-1:0] pin_s;

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (irq_pin_n),
    .q_sync  (pin_s)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    ext_irq_chan i_chan (
      .clk     (clk),
      .rst     (rst),
      .pin_s   (pin_s[p]),
      .stb     (sample_stb),
      .we      (reg_we),
      .wr_mode (reg_wdata[mode_bit(p)]),
      .wr_flag (reg_wdata[flag_bit(p)]),
      .vclr    (vec_clr[p]),
      .mode_q  (reg_rdata[mode_bit(p)]),
      .flag_q  (reg_rdata[flag_bit(p)]),
      .req_q   (irq_req[p])
    );
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && reg_rdata == '0));
endmodule

// File: tb/test_ext_irq_cond.sv
module test_ext_irq_cond;
  localparam int NP = 2;
  localparam int RW = 2 * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '1;
  logic          stb = 1'b0;
  logic          we = 1'b0;
  logic [RW-1:0] wd = '0;
  logic [NP-1:0] clr = '0;
  logic [NP-1:0] req;
  logic [RW-1:0] rd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_cond #(.NUM_PINS(NP)) i_ext_irq_cond (
    .clk(clk), .rst(rst), .irq_pin_n(pins), .sample_stb(stb),
    .reg_we(we), .reg_wdata(wd), .vec_clr(clr),
    .irq_req(req), .reg_rdata(rd)
  );

  // {pins[1:0], expected req[1:0], expected rdata[3:0]}; pin0 falling-edge, pin1 low-level
  localparam logic [7:0] VEC [5] = '{
    8'b11_00_0001,
    8'b10_01_0011,
    8'b10_01_0011,
    8'b00_11_0011,
    8'b11_01_0011
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // drive pins, let two edges pass through the synchronizer, then strobe with optional clr/write
  task automatic step(input logic [NP-1:0] p, input logic [NP-1:0] c,
                      input logic w, input logic [RW-1:0] d);
    pins = p;
    repeat (2) @(negedge clk);
    stb = 1'b1; clr = c; we = w; wd = d;
    @(negedge clk);
    stb = 1'b0; clr = '0; we = 1'b0;
  endtask

  task automatic wr(input logic [RW-1:0] d);
    we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic vclear(input logic [NP-1:0] c);
    clr = c;
    @(negedge clk);
    clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset req", 8'(req), 8'h0);
    check("R1 reset rdata", 8'(rd), 8'h0);

    wr(4'b0001);
    check("R2 write next clock", 8'(rd), 8'h1);

    for (int i = 0; i < 5; i++) begin
      step(VEC[i][7:6], 2'b00, 1'b0, '0);
      check($sformatf("R4/R8 vector %0d req", i), 8'(req), 8'(VEC[i][5:4]));
      check($sformatf("R4/R8 vector %0d rdata", i), 8'(rd), 8'(VEC[i][3:0]));
    end

    vclear(2'b01);
    check("R6 vec clear flag", 8'(rd), 8'h1);
    check("R6 vec clear req", 8'(req), 8'h0);

    // strobe on the second edge after the change: synchronizer not yet through
    pins = 2'b10;
    @(negedge clk);
    stb = 1'b1;
    @(negedge clk);
    check("R3 early strobe ignored", 8'(rd), 8'h1);
    @(negedge clk);
    stb = 1'b0;
    check("R4 third edge strobe sets", 8'(rd), 8'h3);

    vclear(2'b01);
    step(2'b10, 2'b00, 1'b0, '0);
    check("R5 held low no reset", 8'(rd), 8'h1);
    step(2'b11, 2'b00, 1'b0, '0);
    check("R5 high sample", 8'(rd), 8'h1);
    step(2'b10, 2'b00, 1'b0, '0);
    check("R5 re-armed edge", 8'(rd), 8'h3);

    vclear(2'b01);
    step(2'b11, 2'b00, 1'b0, '0);
    pins = 2'b10;
    repeat (3) @(negedge clk);
    step(2'b11, 2'b00, 1'b0, '0);
    check("R3 pulse between strobes", 8'(rd), 8'h1);

    step(2'b10, 2'b01, 1'b0, '0);
    check("R7 edge beats clear", 8'(rd), 8'h3);
    vclear(2'b01);
    step(2'b11, 2'b00, 1'b0, '0);
    step(2'b10, 2'b00, 1'b1, 4'b0001);
    check("R7 edge beats write", 8'(rd), 8'h3);

    vclear(2'b01);
    step(2'b01, 2'b00, 1'b0, '0);
    check("R8 level request", 8'(req), 8'h2);
    check("R8 level flag untouched", 8'(rd), 8'h1);
    vclear(2'b10);
    check("R9 clear ignored in level", 8'(req), 8'h2);
    step(2'b01, 2'b00, 1'b0, '0);
    check("R9 still low requests", 8'(req), 8'h2);
    wr(4'b1001);
    check("R8 written flag", 8'(rd), 8'h9);
    step(2'b11, 2'b00, 1'b0, '0);
    check("R8 flag ignored in level", 8'(req), 8'h0);

    wr(4'b0101);
    step(2'b01, 2'b00, 1'b0, '0);
    check("R2 pin1 edge mode bit2 flag bit3", 8'(rd), 8'hD);
    check("R2 pin1 edge request", 8'(req), 8'h2);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset again req", 8'(req), 8'h0);
    check("R1 reset again rdata", 8'(rd), 8'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule